// File: doc/BRIEF.md
# Type-Keyed Inline Dispatch Fetch Unit

This block is the instruction-fetch front end of a processor that runs message sends with a per-call-site dispatch cache. In ordinary operation it reads the word at the program counter from a code memory and offers it to the decoder through a valid/ready handshake. When the decoder takes a send instruction, the unit stops fetching and waits for the execution side to report the receiver's type. It then looks up a cache line selected by the pair (send address, type). The words of that line are issued as though they were placed in the code right after the send. The program counter stays on the send while the line streams. Once the line's used slots are consumed, fetch continues at the word after the send.

The cache is direct-mapped. The index is a hash of the 64-bit key, built by folding it with XOR. Software manages the cache and writes whole lines through a fill port. A lookup that finds no line raises a trap that shows the faulting key, and the unit stalls until software answers with a retry pulse. A redirect from a taken branch or call overrides every mode, including the stream from a cache line and the trap.

Top module: `pic_fetch_unit`

## Requirements
- R1: After reset the unit fetches at address 0 with `out_valid` high, `out_pic` low and `trap` low, and every cache line is invalid.
- R2: In fetch-from-memory mode, `cm_addr` equals the PC and `out_insn` equals `cm_data`. An accepted word that is not a send advances the PC by one. A word that is not accepted leaves the PC unchanged.
- R3: A word whose bits [31:28] equal 4'hF is a send. Once a send is accepted, `out_valid` goes low and `cm_addr` holds the send's address until `type_valid` delivers the receiver type.
- R4: The lookup key is {PC[31:0], type[31:0]}. The set index is bit-wise XOR over all key bits i into index bit i mod 6. A hit requires a valid line whose stored 64-bit key equals the lookup key, so a different key that lands in the same set misses.
- R5: The lookup is made on the cycle after `type_valid`. On a hit, the following cycle shows `out_pic` high and `out_insn` equal to slot 0, where slot i is `fill_words[32*i+31:32*i]`. Each accepted word advances to the next slot, and `cm_addr` stays at the send's address throughout.
- R6: A line issues min(count, 8) slots. After its last slot is accepted the unit fetches from memory at send address + 1. A count of 0 goes straight to send address + 1 without issuing any word.
- R7: On a miss, `trap` is high, `trap_key` shows the lookup key and `out_valid` is low. All three hold until `retry`, which repeats the lookup on the next cycle.
- R8: `redir_valid` takes priority in every state. On the next cycle the unit fetches from memory at `redir_pc` with `trap` and `out_pic` low.
- R9: `fill_we` writes key, valid bit, count and all eight words into the set that the hash of `fill_key` selects, and the write is seen by the next lookup. Writing `fill_valid`=0 makes later lookups of that key miss. A fill must not target the set being streamed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cm_addr | output | 32 | Code memory read address (current PC) |
| cm_data | input | 32 | Code memory read data, same cycle |
| out_valid | output | 1 | Instruction offered |
| out_ready | input | 1 | Instruction taken by the decoder |
| out_insn | output | 32 | Offered instruction word |
| out_pic | output | 1 | Offered word comes from a cache line |
| type_valid | input | 1 | Receiver type for the pending send is present |
| type_val | input | 32 | Receiver type |
| redir_valid | input | 1 | Taken branch or call |
| redir_pc | input | 32 | Redirect target |
| fill_we | input | 1 | Write one cache line |
| fill_valid | input | 1 | Valid bit to store |
| fill_key | input | 64 | Key {PC, type} of the line |
| fill_count | input | 4 | Number of used slots |
| fill_words | input | 256 | Eight slot words, slot 0 in the low bits |
| retry | input | 1 | Repeat the lookup after a miss |
| trap | output | 1 | Lookup missed |
| trap_key | output | 64 | Key of the missed lookup |

## Verification
On every cycle, assertions check that the PC takes each redirect target, that it steps by one after an accepted ordinary word, and that it stays frozen while the unit waits for a type, is trapped, or is partway through a line. They also check that a trapped unit keeps its key until a retry, that a fill lands in the set it names, and that no fill hits the set being streamed. Only the bench scenarios can show that a line's words arrive in slot order, that short, empty and over-long counts end at the right place, that an aliased key misses, and that an invalidated line traps again.

// File: rtl/pic_fetch_pkg.sv
package pic_fetch_pkg;
  typedef enum logic [2:0] {
    ST_NORM  = 3'd0,
    ST_WTYPE = 3'd1,
    ST_LOOK  = 3'd2,
    ST_PIC   = 3'd3,
    ST_MISS  = 3'd4
  } fetch_st_t;
endpackage

// File: rtl/pic_key_hash.sv
module pic_key_hash #(
  parameter int KEY_W = 64,
  parameter int IDX_W = 6
) (
  input  logic [KEY_W-1:0] key_i,
  output logic [IDX_W-1:0] idx_o
);
  // Fold: key bit i lands on index bit i mod IDX_W.
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < KEY_W; i++) begin
      idx_o[i % IDX_W] = idx_o[i % IDX_W] ^ key_i[i];
    end
  end
endmodule

// File: rtl/pic_line_store.sv
module pic_line_store #(
  parameter int KEY_W  = 64,
  parameter int IDX_W  = 6,
  parameter int INSN_W = 32,
  parameter int SLOTS  = 8,
  parameter int CNT_W  = 4,
  parameter int SLOT_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [IDX_W-1:0]        wr_set_i,
  input  logic                    wr_valid_i,
  input  logic [KEY_W-1:0]        wr_tag_i,
  input  logic [CNT_W-1:0]        wr_cnt_i,
  input  logic [SLOTS*INSN_W-1:0] wr_words_i,
  input  logic [IDX_W-1:0]        rd_set_i,
  input  logic [SLOT_W-1:0]       rd_sel_i,
  output logic                    rd_valid_o,
  output logic [KEY_W-1:0]        rd_tag_o,
  output logic [CNT_W-1:0]        rd_cnt_o,
  output logic [INSN_W-1:0]       rd_word_o
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]         vld_w;
  logic [KEY_W-1:0]        tag_w [SETS];
  logic [CNT_W-1:0]        cnt_w [SETS];
  logic [SLOTS*INSN_W-1:0] dat_w [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic                    v_q;
    logic [KEY_W-1:0]        tag_q;
    logic [CNT_W-1:0]        cnt_q;
    logic [SLOTS*INSN_W-1:0] dat_q;
    logic                    we;

    assign we = wr_en_i && (wr_set_i == IDX_W'(s));

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)  v_q <= 1'b0;
      else if (we)  v_q <= wr_valid_i;
    end

    always_ff @(posedge clk) begin
      if (we) begin
        tag_q <= wr_tag_i;
        cnt_q <= wr_cnt_i;
        dat_q <= wr_words_i;
      end
    end

    assign vld_w[s] = v_q;
    assign tag_w[s] = tag_q;
    assign cnt_w[s] = cnt_q;
    assign dat_w[s] = dat_q;
  end

  assign rd_valid_o = vld_w[rd_set_i];
  assign rd_tag_o   = tag_w[rd_set_i];
  assign rd_cnt_o   = cnt_w[rd_set_i];
  assign rd_word_o  = dat_w[rd_set_i][int'(rd_sel_i)*INSN_W +: INSN_W];

  // R9: a fill sets the valid bit of the addressed set as requested
  p_fill_lands_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en_i |=> (vld_w[$past(wr_set_i)] == $past(wr_valid_i)));
endmodule

// File: rtl/pic_fetch_seq.sv
module pic_fetch_seq
  import pic_fetch_pkg::*;
#(
  parameter int               PC_W     = 32,
  parameter int               TYPE_W   = 32,
  parameter int               SLOTS    = 8,
  parameter int               CNT_W    = 4,
  parameter int               SLOT_W   = 3,
  parameter int               OPC_W    = 4,
  parameter logic [OPC_W-1:0] SEND_OP  = 4'hF,
  parameter logic [PC_W-1:0]  RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              out_ready_i,
  input  logic [OPC_W-1:0]  opc_i,
  input  logic              type_valid_i,
  input  logic [TYPE_W-1:0] type_val_i,
  input  logic              redir_valid_i,
  input  logic [PC_W-1:0]   redir_pc_i,
  input  logic              retry_i,
  input  logic              hit_i,
  input  logic [CNT_W-1:0]  line_cnt_i,
  output fetch_st_t         st_o,
  output logic [PC_W-1:0]   pc_o,
  output logic [TYPE_W-1:0] typ_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              out_valid_o
);
  fetch_st_t         st_q, st_n;
  logic [PC_W-1:0]   pc_q, pc_n;
  logic [TYPE_W-1:0] typ_q;
  logic [SLOT_W-1:0] slot_q, slot_n;
  logic              pc_en, typ_en, slot_en;
  logic              fire, last, is_send;
  logic [CNT_W-1:0]  cnt_eff;

  assign out_valid_o = (st_q == ST_NORM) || (st_q == ST_PIC);
  assign fire        = out_valid_o && out_ready_i;
  assign is_send     = (opc_i == SEND_OP);
  assign cnt_eff     = (line_cnt_i > CNT_W'(SLOTS)) ? CNT_W'(SLOTS) : line_cnt_i;
  assign last        = (CNT_W'(slot_q) + CNT_W'(1)) >= cnt_eff;

  always_comb begin
    st_n    = st_q;
    pc_n    = pc_q + PC_W'(1);
    slot_n  = slot_q + SLOT_W'(1);
    pc_en   = 1'b0;
    typ_en  = 1'b0;
    slot_en = 1'b0;
    if (redir_valid_i) begin
      st_n  = ST_NORM;
      pc_n  = redir_pc_i;
      pc_en = 1'b1;
    end else begin
      unique case (st_q)
        ST_NORM: if (fire) begin
          if (is_send) st_n = ST_WTYPE;
          else         pc_en = 1'b1;
        end
        ST_WTYPE: if (type_valid_i) begin
          typ_en = 1'b1;
          st_n   = ST_LOOK;
        end
        ST_LOOK: begin
          if (!hit_i) begin
            st_n = ST_MISS;
          end else if (cnt_eff == '0) begin
            st_n  = ST_NORM;
            pc_en = 1'b1;
          end else begin
            st_n    = ST_PIC;
            slot_n  = '0;
            slot_en = 1'b1;
          end
        end
        ST_PIC: if (fire) begin
          if (last) begin
            st_n  = ST_NORM;
            pc_en = 1'b1;
          end else begin
            slot_en = 1'b1;
          end
        end
        ST_MISS: if (retry_i) st_n = ST_LOOK;
        default: st_n = ST_NORM;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_NORM;
      pc_q   <= RESET_PC;
      typ_q  <= '0;
      slot_q <= '0;
    end else begin
      st_q <= st_n;
      if (pc_en)   pc_q   <= pc_n;
      if (typ_en)  typ_q  <= type_val_i;
      if (slot_en) slot_q <= slot_n;
    end
  end

  assign st_o   = st_q;
  assign pc_o   = pc_q;
  assign typ_o  = typ_q;
  assign slot_o = slot_q;

  // R8: redirect wins and lands in memory-fetch mode
  p_redirect_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    redir_valid_i |=> (pc_q == $past(redir_pc_i)) && (st_q == ST_NORM));
  // R2: accepted ordinary word steps the PC
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_NORM && fire && !is_send && !redir_valid_i)
      |=> (pc_q == $past(pc_q) + PC_W'(1)));
  // R3: PC frozen while the type is awaited
  p_wait_frozen_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_WTYPE && !redir_valid_i) |=> $stable(pc_q));
  // R5: PC frozen inside a line
  p_line_frozen_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_PIC && !(fire && last) && !redir_valid_i)
      |=> $stable(pc_q) && (st_q == ST_PIC));
  // R7: miss holds its key until retry
  p_miss_hold_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_MISS && !retry_i && !redir_valid_i)
      |=> (st_q == ST_MISS) && $stable(pc_q) && $stable(typ_q));
endmodule

// File: rtl/pic_fetch_unit.sv
module pic_fetch_unit
  import pic_fetch_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int TYPE_W = 32,
  parameter int INSN_W = 32,
  parameter int IDX_W  = 6,
  parameter int SLOTS  = 8,
  parameter int OPC_W  = 4,
  parameter logic [OPC_W-1:0] SEND_OP = 4'hF,
  parameter logic [PC_W-1:0]  RESET_PC = '0,
  localparam int KEY_W  = PC_W + TYPE_W,
  localparam int CNT_W  = $clog2(SLOTS + 1),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int LINE_W = SLOTS * INSN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [PC_W-1:0]   cm_addr,
  input  logic [INSN_W-1:0] cm_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [INSN_W-1:0] out_insn,
  output logic              out_pic,
  input  logic              type_valid,
  input  logic [TYPE_W-1:0] type_val,
  input  logic              redir_valid,
  input  logic [PC_W-1:0]   redir_pc,
  input  logic              fill_we,
  input  logic              fill_valid,
  input  logic [KEY_W-1:0]  fill_key,
  input  logic [CNT_W-1:0]  fill_count,
  input  logic [LINE_W-1:0] fill_words,
  input  logic              retry,
  output logic              trap,
  output logic [KEY_W-1:0]  trap_key
);
  logic [1:0]        rst_sync_q;
  logic              rst_i;
  fetch_st_t         st;
  logic [PC_W-1:0]   pc;
  logic [TYPE_W-1:0] typ;
  logic [SLOT_W-1:0] slot;
  logic [KEY_W-1:0]  key;
  logic [IDX_W-1:0]  lk_set, fill_set;
  logic              rd_valid, hit;
  logic [KEY_W-1:0]  rd_tag;
  logic [CNT_W-1:0]  rd_cnt;
  logic [INSN_W-1:0] rd_word;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  assign key = {pc, typ};

  pic_key_hash #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_lk_hash (
    .key_i(key), .idx_o(lk_set));
  pic_key_hash #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_fill_hash (
    .key_i(fill_key), .idx_o(fill_set));

  pic_line_store #(
    .KEY_W(KEY_W), .IDX_W(IDX_W), .INSN_W(INSN_W),
    .SLOTS(SLOTS), .CNT_W(CNT_W), .SLOT_W(SLOT_W)
  ) u_store (
    .clk(clk), .rst_ni(rst_i),
    .wr_en_i(fill_we), .wr_set_i(fill_set), .wr_valid_i(fill_valid),
    .wr_tag_i(fill_key), .wr_cnt_i(fill_count), .wr_words_i(fill_words),
    .rd_set_i(lk_set), .rd_sel_i(slot),
    .rd_valid_o(rd_valid), .rd_tag_o(rd_tag), .rd_cnt_o(rd_cnt),
    .rd_word_o(rd_word));

  assign hit = rd_valid && (rd_tag == key);

  pic_fetch_seq #(
    .PC_W(PC_W), .TYPE_W(TYPE_W), .SLOTS(SLOTS), .CNT_W(CNT_W),
    .SLOT_W(SLOT_W), .OPC_W(OPC_W), .SEND_OP(SEND_OP), .RESET_PC(RESET_PC)
  ) u_seq (
    .clk(clk), .rst_ni(rst_i),
    .out_ready_i(out_ready), .opc_i(cm_data[INSN_W-1 -: OPC_W]),
    .type_valid_i(type_valid), .type_val_i(type_val),
    .redir_valid_i(redir_valid), .redir_pc_i(redir_pc),
    .retry_i(retry), .hit_i(hit), .line_cnt_i(rd_cnt),
    .st_o(st), .pc_o(pc), .typ_o(typ), .slot_o(slot),
    .out_valid_o(out_valid));

  assign cm_addr  = pc;
  assign out_pic  = (st == ST_PIC);
  assign out_insn = out_pic ? rd_word : cm_data;
  assign trap     = (st == ST_MISS);
  assign trap_key = key;

  // R9: software may not rewrite the set being streamed
  p_fill_live_set_r9: assert property (@(posedge clk) disable iff (!rst_i)
    (out_pic && fill_we) |-> (fill_set != lk_set));
  // R5: a line only streams once a matching lookup was made
  p_stream_needs_hit_r5: assert property (@(posedge clk) disable iff (!rst_i)
    (!out_pic ##1 out_pic) |-> $past(hit));
endmodule

// File: tb/sim_pic_fetch_unit.sv
module sim_pic_fetch_unit;
  typedef struct packed {
    logic        rdy;
    logic        rv;
    logic [31:0] rpc;
    logic [31:0] exp_addr;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 1'b0, 32'h0,   32'h1},
    '{1'b0, 1'b0, 32'h0,   32'h1},
    '{1'b1, 1'b0, 32'h0,   32'h2},
    '{1'b1, 1'b1, 32'h100, 32'h100},
    '{1'b1, 1'b0, 32'h0,   32'h101},
    '{1'b0, 1'b1, 32'h20,  32'h20},
    '{1'b1, 1'b0, 32'h0,   32'h21},
    '{1'b1, 1'b0, 32'h0,   32'h22}
  };
  localparam logic [31:0] SEND_AT = 32'h40;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  cm_addr, cm_data, out_insn;
  logic         out_valid, out_pic, trap;
  logic         out_ready = 1'b0, type_valid = 1'b0, redir_valid = 1'b0;
  logic [31:0]  type_val = '0, redir_pc = '0;
  logic         fill_we = 1'b0, fill_valid = 1'b0, retry = 1'b0;
  logic [63:0]  fill_key = '0, trap_key;
  logic [3:0]   fill_count = '0;
  logic [255:0] fill_words = '0;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] code_word(logic [31:0] a);
    return (a == SEND_AT) ? 32'hF000_0000 : {4'h1, a[27:0]};
  endfunction
  function automatic logic [31:0] slot_word(logic [31:0] t, int i);
    return 32'hA000_0000 | (t << 8) | 32'(i);
  endfunction

  assign cm_data = code_word(cm_addr);

  pic_fetch_unit u0 (
    .clk(clk), .rst_n(rst_n), .cm_addr(cm_addr), .cm_data(cm_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_insn(out_insn),
    .out_pic(out_pic), .type_valid(type_valid), .type_val(type_val),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .fill_we(fill_we),
    .fill_valid(fill_valid), .fill_key(fill_key), .fill_count(fill_count),
    .fill_words(fill_words), .retry(retry), .trap(trap), .trap_key(trap_key));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic redirect(logic [31:0] tgt);
    redir_valid = 1'b1; redir_pc = tgt;
    step();
    redir_valid = 1'b0;
  endtask

  // send at SEND_AT, hand over type, return after the lookup cycle
  task automatic send_with(logic [31:0] t);
    redirect(SEND_AT);
    chk("R3 send word", 64'(out_insn[31:28]), 64'hF);
    out_ready = 1'b1;
    step();
    out_ready = 1'b0;
    chk("R3 stall valid", 64'(out_valid), 64'h0);
    step();
    chk("R3 addr held", 64'(cm_addr), 64'(SEND_AT));
    type_valid = 1'b1; type_val = t;
    step();
    type_valid = 1'b0;
    step();
  endtask

  task automatic fill(logic [31:0] t, logic v, logic [3:0] n);
    fill_we = 1'b1; fill_valid = v; fill_key = {SEND_AT, t}; fill_count = n;
    for (int i = 0; i < 8; i++) fill_words[32*i +: 32] = slot_word(t, i);
    step();
    fill_we = 1'b0;
  endtask

  task automatic stream(logic [31:0] t, int n);
    for (int i = 0; i < n; i++) begin
      chk("R5 pic flag", 64'(out_pic), 64'h1);
      chk("R5 slot word", 64'(out_insn), 64'(slot_word(t, i)));
      chk("R5 pc frozen", 64'(cm_addr), 64'(SEND_AT));
      out_ready = 1'b1;
      step();
      out_ready = 1'b0;
    end
    chk("R6 resume addr", 64'(cm_addr), 64'(SEND_AT + 1));
    chk("R6 resume mode", 64'(out_pic), 64'h0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    // R1 reset state
    chk("R1 addr", 64'(cm_addr), 64'h0);
    chk("R1 valid", 64'(out_valid), 64'h1);
    chk("R1 pic", 64'(out_pic), 64'h0);
    chk("R1 trap", 64'(trap), 64'h0);

    // R2 and R8 vector walk in memory-fetch mode
    foreach (VECS[k]) begin
      chk("R2 insn", 64'(out_insn), 64'(code_word(cm_addr)));
      out_ready = VECS[k].rdy; redir_valid = VECS[k].rv; redir_pc = VECS[k].rpc;
      step();
      out_ready = 1'b0; redir_valid = 1'b0;
      chk(VECS[k].rv ? "R8 vec addr" : "R2 vec addr", 64'(cm_addr), 64'(VECS[k].exp_addr));
    end

    // R7 miss on empty cache (R1 lines invalid)
    send_with(32'h1);
    chk("R7 trap", 64'(trap), 64'h1);
    chk("R7 key", trap_key, {SEND_AT, 32'h1});
    chk("R7 stall", 64'(out_valid), 64'h0);
    step();
    chk("R7 trap held", 64'(trap), 64'h1);
    fill(32'h1, 1'b1, 4'd3);
    chk("R7 held after fill", 64'(trap), 64'h1);
    retry = 1'b1;
    step();
    retry = 1'b0;
    step();
    chk("R7 retry clears", 64'(trap), 64'h0);
    stream(32'h1, 3);

    // R5 hold without ready, then R8 redirect mid-line
    send_with(32'h1);
    step(); step();
    chk("R5 held word", 64'(out_insn), 64'(slot_word(32'h1, 0)));
    out_ready = 1'b1;
    step();
    out_ready = 1'b0;
    chk("R5 second word", 64'(out_insn), 64'(slot_word(32'h1, 1)));
    redirect(32'h300);
    chk("R8 exit addr", 64'(cm_addr), 64'h300);
    chk("R8 exit mode", 64'(out_pic), 64'h0);

    // R6 empty line
    fill(32'h2, 1'b1, 4'd0);
    send_with(32'h2);
    chk("R6 empty addr", 64'(cm_addr), 64'(SEND_AT + 1));
    chk("R6 empty mode", 64'(out_pic), 64'h0);
    chk("R6 empty valid", 64'(out_valid), 64'h1);

    // R6 over-long count acts as eight
    fill(32'h4, 1'b1, 4'd15);
    send_with(32'h4);
    stream(32'h4, 8);

    // R4 alias: same set as type 1, other key
    send_with(32'h1 ^ 32'hFFF);
    chk("R4 alias miss", 64'(trap), 64'h1);
    chk("R4 alias key", trap_key, {SEND_AT, 32'h1 ^ 32'hFFF});
    redirect(32'h200);
    chk("R8 trap cleared", 64'(trap), 64'h0);
    chk("R8 trap addr", 64'(cm_addr), 64'h200);

    // R9 invalidate type 1
    fill(32'h1, 1'b0, 4'd3);
    send_with(32'h1);
    chk("R9 invalidated", 64'(trap), 64'h1);
    redirect(32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule